// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting watchdog timer with a refresh window. Software programs it over a small register bus. A control register selects four things: the prescaler ratio, the timeout period, and the two window limits. A reset-control register chooses what happens on a fault, and a debug register can freeze the count.

The counter does not run after reset. It starts only when software writes 00h to the refresh register and then writes FFh to it as the very next bus write. The same pair restarts the count while the timer runs, but only when the count lies inside the programmed window.

A fault is either an underflow of the count or a refresh that lands outside the window. Each fault sets a sticky flag in the status register, stops the counter, and emits a one-cycle pulse. The pulse goes to the reset output or to the interrupt output, depending on the action bit.

Top module: `window_wdog`

## Requirements
- R1: After reset, the registers read as follows: control (0x0) 3303h, status (0x4) 0000h, action (0x6) 00h and debug (0x8) 0000h. Both outputs are low and the counter is idle at 0.
- R2: The counter starts only on a write of 00h to the refresh register (0x2) followed by a write of FFh to it as the next bus write. An FFh without a preceding 00h has no effect. Any other write between the two aborts the sequence, and the counter stays idle.
- R3: The period field, control bits [1:0], loads the counter with 1023, 4095, 8191 or 16383 for codes 00b, 01b, 10b and 11b. With a divide ratio of 1, the underflow occurs on the 1024th clock after the sequence completes when the period code is 00b.
- R4: The divider field, control bits [7:4], makes the count decrement once every 1, 4, 256 or 8192 clocks for codes 0000b, 0100b, 0101b and 1000b. Any other code divides by 1. The prescaler restarts on every accepted refresh.
- R5: The window is open while end_limit <= count <= start_limit, where T is the loaded period. Start code (bits [13:12]) 00b, 01b, 10b or 11b sets start_limit to T/4, T/2, T-T/4 or T. End code (bits [9:8]) 00b, 01b, 10b or 11b sets end_limit to T-T/4, T/2, T/4 or 0. All divisions are integer divisions.
- R6: If the timer is running, a refresh sequence inside the window reloads the count with T. A refresh sequence outside the window sets the refresh-error flag (status bit 15), fires the selected action and stops the counter at its current value.
- R7: An underflow occurs when a decrement is due while the count is 0. It sets the underflow flag (status bit 14), fires the selected action and stops the counter at 0.
- R8: With action bit 7 set to 1, a fault produces a one-cycle high pulse on wdt_rst_o. With bit 7 at 0, it produces a one-cycle pulse on wdt_irq_o. The pulse appears in the clock after the fault edge, and the two outputs are never high together.
- R9: While debug bit 0 is 1, the count and the prescaler hold their values. Clearing the bit resumes counting from the held value.
- R10: Status bits [13:0] read the current count. Writing 0 to bit 14 or bit 15 clears that flag, and writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| wdt_rst_o | output | 1 | One-cycle reset request |
| wdt_irq_o | output | 1 | One-cycle interrupt request |

## Verification
The hardest conditions to reach are a refresh at a known position relative to the window edges, and an underflow observed on its exact cycle. Each table vector programs a window, starts the counter, and waits a fixed number of clocks that places the count well inside or well outside the window before it refreshes. The directed tests then count clocks from the write that completes the sequence to catch the underflow pulse on its exact cycle. They also read the live count through the status register to check each divider ratio and the debug freeze.

// File: rtl/window_wdog.sv
module window_wdog (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        wdt_rst_o,
  output logic        wdt_irq_o
);
  localparam int CW = 14;
  localparam int PW = 13;

  logic [3:0]    div_sel;
  logic [1:0]    per_sel, wbeg_sel, wend_sel;
  logic          act_rst, halt, run, armed, f_uf, f_err, rst_q, irq_q;
  logic [CW-1:0] cnt, top, q1, q2, q3, beg_thr, end_thr;
  logic [PW-1:0] pre, div_lim;

  always_comb begin
    case (per_sel)
      2'd0:    top = CW'(1023);
      2'd1:    top = CW'(4095);
      2'd2:    top = CW'(8191);
      default: top = CW'(16383);
    endcase
    case (div_sel)
      4'b0100: div_lim = PW'(3);
      4'b0101: div_lim = PW'(255);
      4'b1000: div_lim = PW'(8191);
      default: div_lim = '0;
    endcase
  end

  assign q1 = top >> 2;
  assign q2 = top >> 1;
  assign q3 = top - q1;

  always_comb begin
    case (wbeg_sel)
      2'd0:    beg_thr = q1;
      2'd1:    beg_thr = q2;
      2'd2:    beg_thr = q3;
      default: beg_thr = top;
    endcase
    case (wend_sel)
      2'd0:    end_thr = q3;
      2'd1:    end_thr = q2;
      2'd2:    end_thr = q1;
      default: end_thr = '0;
    endcase
  end

  wire in_win   = (cnt <= beg_thr) && (cnt >= end_thr);
  wire wr_ref   = bus_we && (bus_addr == 4'h2);
  wire seq_done = wr_ref && armed && (bus_wdata[7:0] == 8'hFF);
  wire tick     = run && !halt && (pre == div_lim);
  wire uf_ev    = tick && (cnt == '0);
  wire err_ev   = seq_done && run && !in_win;
  wire ev       = uf_ev || err_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel  <= '0;
      per_sel  <= 2'd3;
      wbeg_sel <= 2'd3;
      wend_sel <= 2'd3;
      act_rst  <= 1'b0;
      halt     <= 1'b0;
      cnt      <= '0;
      pre      <= '0;
      run      <= 1'b0;
      armed    <= 1'b0;
      f_uf     <= 1'b0;
      f_err    <= 1'b0;
      rst_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      rst_q <= ev && act_rst;
      irq_q <= ev && !act_rst;
      if (bus_we) armed <= wr_ref && (bus_wdata[7:0] == 8'h00);
      if (bus_we) begin
        case (bus_addr)
          4'h0: begin
            wbeg_sel <= bus_wdata[13:12];
            wend_sel <= bus_wdata[9:8];
            div_sel  <= bus_wdata[7:4];
            per_sel  <= bus_wdata[1:0];
          end
          4'h4: begin
            if (!bus_wdata[14]) f_uf  <= 1'b0;
            if (!bus_wdata[15]) f_err <= 1'b0;
          end
          4'h6: act_rst <= bus_wdata[7];
          4'h8: halt    <= bus_wdata[0];
          default: ;
        endcase
      end
      if (uf_ev)  f_uf  <= 1'b1;
      if (err_ev) f_err <= 1'b1;
      if (ev) begin
        run <= 1'b0;
      end else if (seq_done) begin
        run <= 1'b1;
        cnt <= top;
        pre <= '0;
      end else if (run && !halt) begin
        if (tick) begin
          pre <= '0;
          cnt <= cnt - 1'b1;
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = {2'b00, wbeg_sel, 2'b00, wend_sel, div_sel, 2'b00, per_sel};
      4'h4:    bus_rdata = {f_err, f_uf, cnt};
      4'h6:    bus_rdata = {8'h00, act_rst, 7'h00};
      4'h8:    bus_rdata = {15'h0000, halt};
      default: bus_rdata = '0;
    endcase
  end

  assign wdt_rst_o = rst_q;
  assign wdt_irq_o = irq_q;
endmodule

// File: rtl/window_wdog_chk.sv
module window_wdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic        stop,
  input logic        run,
  input logic [13:0] cnt,
  input logic        rst_o,
  input logic        irq_o,
  input logic        f_uf,
  input logic        f_err
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rst_o && irq_o)); // R8
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rst_o |=> !rst_o); // R8
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq_o |=> !irq_o); // R8
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop) && !$past(we)) |-> $stable(cnt)); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(stop) && !$past(we) && $past(cnt) != 14'd0)
      |-> (cnt == $past(cnt) || cnt == $past(cnt) - 14'd1)); // R4
  AST_UF_FIRES: assert property (@(posedge clk) disable iff (!rst_n) $rose(f_uf) |-> (rst_o || irq_o)); // R7
  AST_ERR_FIRES: assert property (@(posedge clk) disable iff (!rst_n) $rose(f_err) |-> (rst_o || irq_o)); // R6
endmodule

bind window_wdog window_wdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we(bus_we), .stop(halt), .run(run), .cnt(cnt),
  .rst_o(wdt_rst_o), .irq_o(wdt_irq_o), .f_uf(f_uf), .f_err(f_err)
);

// File: tb/tb_window_wdog.sv
module tb_window_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        wdt_rst_o, wdt_irq_o;
  int          n_chk = 0, n_err = 0, n_rst = 0, n_irq = 0;

  window_wdog dut (.*);

  always #4 clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    n_rst += int'(wdt_rst_o);
    n_irq += int'(wdt_irq_o);
  end

  // {control, clocks before refresh, expected refresh error}, divide 1, T=1023
  localparam logic [31:0] VEC [10] = '{
    {16'h3300, 15'd100, 1'b0}, {16'h0300, 15'd100, 1'b1},
    {16'h0300, 15'd900, 1'b0}, {16'h1200, 15'd600, 1'b0},
    {16'h1200, 15'd900, 1'b1}, {16'h3000, 15'd100, 1'b0},
    {16'h3000, 15'd400, 1'b1}, {16'h0000, 15'd900, 1'b1},
    {16'h2300, 15'd100, 1'b1}, {16'h2300, 15'd400, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start();
    wr(4'h2, 16'h0000);
    wr(4'h2, 16'h00FF);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog timeout actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v, c1, c2;
    int r0, i0;
    do_reset();
    rd(4'h0, v); chk("R1 control reset", v, 16'h3303);
    rd(4'h4, v); chk("R1 status reset", v, 16'h0000);
    rd(4'h6, v); chk("R1 action reset", v, 16'h0000);
    rd(4'h8, v); chk("R1 debug reset", v, 16'h0000);
    chk("R1 outputs low", {wdt_rst_o, wdt_irq_o}, 2'b00);

    for (int i = 0; i < 10; i++) begin
      do_reset();
      wr(4'h0, VEC[i][31:16]);
      wr(4'h6, (i % 2) ? 16'h0080 : 16'h0000);
      start();
      repeat (VEC[i][15:1]) @(negedge clk);
      r0 = n_rst; i0 = n_irq;
      start();
      rd(4'h4, v);
      chk($sformatf("R5 vector %0d error flag", i), v[15], VEC[i][0]);
      if (!VEC[i][0]) chk($sformatf("R6 vector %0d reload", i), v[13:0], 14'd1023);
      @(negedge clk); #1;
      if (VEC[i][0]) begin
        if (i % 2) chk($sformatf("R8 vector %0d reset pulse", i), n_rst - r0, 1);
        else       chk($sformatf("R8 vector %0d irq pulse", i), n_irq - i0, 1);
        rd(4'h4, c1); repeat (50) @(negedge clk); rd(4'h4, c2);
        chk($sformatf("R6 vector %0d stopped", i), c2, c1);
      end else begin
        chk($sformatf("R6 vector %0d no pulse", i), (n_rst - r0) + (n_irq - i0), 0);
      end
    end

    do_reset();
    wr(4'h2, 16'h00FF); repeat (20) @(negedge clk);
    rd(4'h4, v); chk("R2 lone FF ignored", v, 16'h0000);
    wr(4'h2, 16'h0000); wr(4'h0, 16'h3300); wr(4'h2, 16'h00FF);
    repeat (20) @(negedge clk);
    rd(4'h4, v); chk("R2 interrupted sequence aborted", v, 16'h0000);
    wr(4'h2, 16'h0000); wr(4'h2, 16'h0000); wr(4'h2, 16'h00FF);
    rd(4'h4, v); chk("R2 repeated 00 then FF starts", v, 16'd1023);

    do_reset();
    wr(4'h6, 16'h0080); wr(4'h0, 16'h3300); r0 = n_rst;
    start();
    repeat (1023) @(negedge clk);
    chk("R3 no underflow before 1024 clocks", wdt_rst_o, 1'b0);
    @(negedge clk);
    chk("R8 reset pulse at clock 1024", {wdt_rst_o, wdt_irq_o}, 2'b10);
    rd(4'h4, v); chk("R7 underflow flag and zero count", v, 16'h4000);
    @(negedge clk);
    chk("R8 reset pulse one cycle", wdt_rst_o, 1'b0);

    do_reset(); wr(4'h0, 16'h3301); start(); repeat (10) @(negedge clk);
    rd(4'h4, v); chk("R3 period 01", v, 16'd4085);
    do_reset(); wr(4'h0, 16'h3302); start();
    rd(4'h4, v); chk("R3 period 10", v, 16'd8191);
    do_reset(); start();
    rd(4'h4, v); chk("R3 period 11", v, 16'd16383);

    do_reset(); wr(4'h0, 16'h3340); start(); repeat (40) @(negedge clk);
    rd(4'h4, v); chk("R4 divide 4", v, 16'd1013);
    do_reset(); wr(4'h0, 16'h3350); start(); repeat (768) @(negedge clk);
    rd(4'h4, v); chk("R4 divide 256", v, 16'd1020);
    do_reset(); wr(4'h0, 16'h3380); start(); repeat (16384) @(negedge clk);
    rd(4'h4, v); chk("R4 divide 8192", v, 16'd1021);
    do_reset(); wr(4'h0, 16'h3310); start(); repeat (10) @(negedge clk);
    rd(4'h4, v); chk("R4 other code divides by 1", v, 16'd1013);

    do_reset(); wr(4'h0, 16'h3300); start(); repeat (10) @(negedge clk);
    wr(4'h8, 16'h0001);
    rd(4'h4, c1); repeat (1200) @(negedge clk); rd(4'h4, c2);
    chk("R9 count frozen", c2, c1);
    wr(4'h8, 16'h0000);
    repeat (10) @(negedge clk); rd(4'h4, v);
    chk("R9 count resumes", v, c1 - 16'd10);

    do_reset(); wr(4'h0, 16'h0300); i0 = n_irq;
    start(); start();
    start(); repeat (1030) @(negedge clk);
    chk("R8 irq pulses for error and underflow", n_irq - i0, 2);
    rd(4'h4, v); chk("R10 both flags set", v[15:14], 2'b11);
    wr(4'h4, 16'h4000);
    rd(4'h4, v); chk("R10 clear error keeps underflow", v[15:14], 2'b01);
    wr(4'h4, 16'h0000);
    rd(4'h4, v); chk("R10 clear underflow", v, 16'h0000);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule